// File: doc/BRIEF.md
# Memory-Mapped UART Transmitter with Re-Armable TX-Empty Interrupt

This block is the transmit half of a register-programmed serial port. A processor on a simple synchronous register bus sets the line format and the bit rate, loads bytes into a one-byte holding register, and is told through an interrupt line when that holding register can take another byte. Each byte moves from the holding register into a shift engine. The engine sends an asynchronous frame on a single output pin. The line idles high.

The interrupt behaviour is the centre of the design. Any write to the interrupt-enable register with the TX-empty enable bit set makes the TX-empty interrupt pending again, provided the holding register is empty at that moment. This applies even if software has already acknowledged the interrupt. A read of the identification register acknowledges the interrupt, but only when that read reports TX-empty. A write of a data byte also withdraws the interrupt. When that byte is handed to the shift engine, the holding register is empty again and the interrupt returns.

The bit clock comes from an integer divisor. A fractional multiplier can be switched in by a flag bit, so that rates which are not an integer fraction of the system clock are possible.

Top module: `sertx_core`

## Requirements
- R1: After reset, txd is high, irq is low, the status register (address 5) reads 0x0060, the identification register (address 2) reads 0x0001, and the divisor, enable, format and fractional registers are zero.
- R2: Writing the enable register (address 1, access bit clear) with bit 1 set while the holding register is empty makes the TX-empty interrupt pending. irq is high exactly while an interrupt is pending and enable bit 1 is set. The identification register then reads 0x0002, and it reads 0x0001 otherwise (bit 0 is an active-low "nothing pending" flag).
- R3: A read of the identification register that returns 0x0002 clears the pending interrupt from the next cycle on. A second read returns 0x0001.
- R4: After an acknowledge, writing the enable register again with bit 1 set and the holding register empty raises irq again on the cycle after the write.
- R5: Writing enable bit 1 as zero drops irq on the next cycle. An identification read made meanwhile returns 0x0001.
- R6: Writing address 0 (access bit clear) loads the holding register and drops irq on the next cycle. When the byte is handed to an idle shift engine, one cycle after the write, the holding register is empty again and irq rises if enable bit 1 is set.
- R7: While format bit 7 (divisor access) is set, addresses 0 and 1 read and write the low and high bytes of the 16-bit divisor. The holding register, the enable register and the transmitter are left untouched.
- R8: A frame is one low start bit, then 5 + format[1:0] data bits LSB first, then one high stop bit, or two if format bit 2 is set. Format 0x03 gives 8 data bits and 1 stop bit.
- R9: With fractional mode off, each bit lasts 32 × D clocks, where D is the divisor. A divisor of 0 acts as 1.
- R10: The fractional register (address 4) holds an enable in bit 15, a multiplier M in bits 12:11 and a fraction N in bits 10:0 (M=1, N=730 with enable is 0x8ADA). With the enable set, a bit lasts on average 32 × D × (M + N/2048) clocks. A factor below 1 is treated as 1.
- R11: Status bit 5 is 1 while the holding register is empty. Status bit 6 is 1 while both the holding register and the shift engine are empty. All other status bits read 0.
- R12: A read strobe registers the addressed value on bus_rdata at the next clock edge. The format register (address 3) reads back all 8 bits, and the enable register reads back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| txd | output | 1 | Serial output, idles high |
| irq | output | 1 | TX-empty interrupt request |

## Verification
The bench acknowledges the interrupt and then rewrites the enable register. A design that remembered the acknowledge and would not re-arm would leave irq low at that point. It also reads the identification register while the enable is off: a design that cleared the pending flag on every such read would lose an interrupt that software had only masked. The bench checks that a data write withdraws irq and that irq comes back one cycle later, when the byte moves into the shifter; an off-by-one hand-off or a missing re-assert shows up at that exact cycle. It also decodes frames at several divisor settings, with the fractional multiplier on, with two stop bits, and with a 5-bit word, back to back. A wrong bit period, a wrong bit order or a dropped hand-off between frames would corrupt the decoded bits.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int BUS_W  = 16;
    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;
    localparam int FRAME_W = 12;

    typedef enum logic [ADDR_W-1:0] {
        A_DATA = 3'd0,
        A_IEN  = 3'd1,
        A_IID  = 3'd2,
        A_LCR  = 3'd3,
        A_FRAC = 3'd4,
        A_LSR  = 3'd5
    } reg_addr_e;

    localparam logic [BYTE_W-1:0] IID_NONE = 8'h01;
    localparam logic [BYTE_W-1:0] IID_TXE  = 8'h02;

    // Bit 0 start (low), then the data bits LSB first, then ones for stop and idle.
    function automatic logic [FRAME_W-1:0] build_frame(input logic [BYTE_W-1:0] data,
                                                       input logic [1:0] wl);
        logic [FRAME_W-1:0] f;
        int nbits;
        nbits = 5 + int'(wl);
        for (int i = 0; i < FRAME_W; i++) begin
            if (i == 0)
                f[i] = 1'b0;
            else if (i <= nbits)
                f[i] = data[i-1];
            else
                f[i] = 1'b1;
        end
        return f;
    endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int DIV_W  = 16,
    parameter int M_W    = 2,
    parameter int FRAC_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              frac_en,
    input  logic [M_W-1:0]    frac_m,
    input  logic [FRAC_W-1:0] frac_n,
    output logic              tick
);
    localparam int ACC_W = FRAC_W + M_W + 1;
    localparam logic [ACC_W-1:0] ONE = ACC_W'(1 << FRAC_W);

    typedef struct packed {
        logic [DIV_W-1:0] pre;
        logic [ACC_W-1:0] acc;
        logic             tick;
    } baud_st_t;

    baud_st_t st_d, st_q;
    logic [DIV_W-1:0] div_eff;
    logic [ACC_W-1:0] k_raw, k_eff, sum;

    always_comb begin
        div_eff = (div == '0) ? DIV_W'(1) : div;
        k_raw   = frac_en ? {1'b0, frac_m, frac_n} : ONE;
        k_eff   = (k_raw < ONE) ? ONE : k_raw;
        sum     = st_q.acc + ONE;
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (st_q.pre >= div_eff - DIV_W'(1)) begin
            st_d.pre = '0;
            if (sum >= k_eff) begin
                st_d.acc  = sum - k_eff;
                st_d.tick = 1'b1;
            end else begin
                st_d.acc = sum;
            end
        end else begin
            st_d.pre = st_q.pre + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int OVERSAMPLE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [BYTE_W-1:0] data,
    input  logic [1:0]        wl,
    input  logic              two_stop,
    output logic              busy,
    output logic              txd
);
    localparam int OS_W  = $clog2(OVERSAMPLE);
    localparam int CNT_W = $clog2(FRAME_W);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] frame;
        logic [OS_W-1:0]    sub;
        logic [CNT_W-1:0]   bitn;
        logic [CNT_W-1:0]   last;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (load) begin
                st_d.busy  = 1'b1;
                st_d.frame = build_frame(data, wl);
                st_d.sub   = '0;
                st_d.bitn  = '0;
                st_d.last  = CNT_W'(5) + CNT_W'(wl) + (two_stop ? CNT_W'(2) : CNT_W'(1));
            end
        end else if (tick) begin
            if (st_q.sub == OS_W'(OVERSAMPLE - 1)) begin
                st_d.sub = '0;
                if (st_q.bitn == st_q.last) begin
                    st_d.busy = 1'b0;
                end else begin
                    st_d.frame = {1'b1, st_q.frame[FRAME_W-1:1]};
                    st_d.bitn  = st_q.bitn + CNT_W'(1);
                end
            end else begin
                st_d.sub = st_q.sub + OS_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign txd  = st_q.busy ? st_q.frame[0] : 1'b1;

endmodule

// File: rtl/sertx_regs.sv
module sertx_regs
    import sertx_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int M_W    = 2,
    parameter int FRAC_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              sh_busy,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              load,
    output logic [BYTE_W-1:0] hold_data,
    output logic [1:0]        wl,
    output logic              two_stop,
    output logic [DIV_W-1:0]  div,
    output logic              frac_en,
    output logic [M_W-1:0]    frac_m,
    output logic [FRAC_W-1:0] frac_n,
    output logic              dlab,
    output logic              thre,
    output logic              ier_txe
);
    typedef struct packed {
        logic [BYTE_W-1:0] lcr;
        logic [BYTE_W-1:0] ier;
        logic [DIV_W-1:0]  dl;
        logic [BUS_W-1:0]  frac;
        logic [BYTE_W-1:0] hold;
        logic              thre;
        logic              pend;
        logic [BUS_W-1:0]  rdata;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic              txint;
    logic [BYTE_W-1:0] iid, lsr;
    logic [BUS_W-1:0]  rmux;

    always_comb begin
        txint = st_q.pend && st_q.ier[1];
        iid   = txint ? IID_TXE : IID_NONE;
        lsr   = {1'b0, st_q.thre && !sh_busy, st_q.thre, 5'b0};
        load  = !st_q.thre && !sh_busy;

        case (bus_addr)
            A_DATA:  rmux = st_q.lcr[7] ? BUS_W'(st_q.dl[7:0]) : '0;
            A_IEN:   rmux = st_q.lcr[7] ? BUS_W'(st_q.dl[DIV_W-1:8]) : BUS_W'(st_q.ier);
            A_IID:   rmux = BUS_W'(iid);
            A_LCR:   rmux = BUS_W'(st_q.lcr);
            A_FRAC:  rmux = st_q.frac;
            A_LSR:   rmux = BUS_W'(lsr);
            default: rmux = '0;
        endcase

        st_d = st_q;
        // hand-off to the shift engine empties the holding register
        if (load) begin
            st_d.thre = 1'b1;
            st_d.pend = 1'b1;
        end

        if (bus_wr) begin
            case (bus_addr)
                A_DATA: begin
                    if (st_q.lcr[7]) begin
                        st_d.dl[7:0] = bus_wdata[7:0];
                    end else begin
                        st_d.hold = bus_wdata[BYTE_W-1:0];
                        st_d.thre = 1'b0;
                        st_d.pend = 1'b0;
                    end
                end
                A_IEN: begin
                    if (st_q.lcr[7]) begin
                        st_d.dl[DIV_W-1:8] = bus_wdata[DIV_W-9:0];
                    end else begin
                        st_d.ier = bus_wdata[BYTE_W-1:0];
                        if (bus_wdata[1] && st_q.thre) st_d.pend = 1'b1;
                    end
                end
                A_LCR:   st_d.lcr  = bus_wdata[BYTE_W-1:0];
                A_FRAC:  st_d.frac = bus_wdata;
                default: ;
            endcase
        end

        if (bus_rd) begin
            st_d.rdata = rmux;
            if (bus_addr == A_IID && txint) st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.thre <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign irq       = txint;
    assign hold_data = st_q.hold;
    assign wl        = st_q.lcr[1:0];
    assign two_stop  = st_q.lcr[2];
    assign div       = st_q.dl;
    assign frac_en   = st_q.frac[BUS_W-1];
    assign frac_m    = st_q.frac[FRAC_W+M_W-1:FRAC_W];
    assign frac_n    = st_q.frac[FRAC_W-1:0];
    assign dlab      = st_q.lcr[7];
    assign thre      = st_q.thre;
    assign ier_txe   = st_q.ier[1];

endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter int OVERSAMPLE = 32,
    parameter int DIV_W      = 16,
    parameter int M_W        = 2,
    parameter int FRAC_W     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              txd,
    output logic              irq
);
    logic              tick, load, busy, two_stop, frac_en;
    logic              dlab, thre, ier_txe;
    logic [BYTE_W-1:0] hold_data;
    logic [1:0]        wl;
    logic [DIV_W-1:0]  div;
    logic [M_W-1:0]    frac_m;
    logic [FRAC_W-1:0] frac_n;

    sertx_regs #(.DIV_W(DIV_W), .M_W(M_W), .FRAC_W(FRAC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .sh_busy   (busy),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .load      (load),
        .hold_data (hold_data),
        .wl        (wl),
        .two_stop  (two_stop),
        .div       (div),
        .frac_en   (frac_en),
        .frac_m    (frac_m),
        .frac_n    (frac_n),
        .dlab      (dlab),
        .thre      (thre),
        .ier_txe   (ier_txe)
    );

    sertx_baud #(.DIV_W(DIV_W), .M_W(M_W), .FRAC_W(FRAC_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .div     (div),
        .frac_en (frac_en),
        .frac_m  (frac_m),
        .frac_n  (frac_n),
        .tick    (tick)
    );

    sertx_shift #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (load),
        .data     (hold_data),
        .wl       (wl),
        .two_stop (two_stop),
        .busy     (busy),
        .txd      (txd)
    );

endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       ien_bit,
    input logic       txd,
    input logic       irq,
    input logic       dlab,
    input logic       thre,
    input logic       busy,
    input logic       ier_txe
);
    AST_IID_READ_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == 3'd2 && irq) |=> !irq); // R3

    AST_IEN_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && !dlab && bus_addr == 3'd1 && ien_bit && thre) |=> irq); // R4

    AST_DATA_WRITE_WITHDRAWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !dlab && bus_addr == 3'd0) |=> !irq); // R6

    AST_HANDOFF_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> thre); // R6

    AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd); // R8

    AST_DIV_WRITE_KEEPS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && dlab && bus_addr == 3'd1) |=> $stable(ier_txe)); // R7

endmodule

bind sertx_core sertx_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .ien_bit  (bus_wdata[1]),
    .txd      (txd),
    .irq      (irq),
    .dlab     (dlab),
    .thre     (thre),
    .busy     (busy),
    .ier_txe  (ier_txe)
);

// File: tb/sertx_core_test.sv
`timescale 1ns/1ps
module sertx_core_test;

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IRQ = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  addr;
        logic [15:0] data;
        logic [15:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 32;
    localparam vec_t VEC [NVEC] = '{
        '{OP_RD,  3'd5, 16'h0000, 16'h0060, 4'd11}, // R11 idle status
        '{OP_RD,  3'd2, 16'h0000, 16'h0001, 4'd1},  // R1 nothing pending
        '{OP_IRQ, 3'd0, 16'h0000, 16'h0000, 4'd1},  // R1
        '{OP_WR,  3'd1, 16'h0002, 16'h0000, 4'd2},
        '{OP_IRQ, 3'd0, 16'h0000, 16'h0001, 4'd2},  // R2 armed
        '{OP_RD,  3'd1, 16'h0000, 16'h0002, 4'd12}, // R12 enable readback
        '{OP_RD,  3'd2, 16'h0000, 16'h0002, 4'd2},  // R2 reports TX-empty
        '{OP_IRQ, 3'd0, 16'h0000, 16'h0000, 4'd3},  // R3 acked
        '{OP_RD,  3'd2, 16'h0000, 16'h0001, 4'd3},  // R3
        '{OP_WR,  3'd1, 16'h0002, 16'h0000, 4'd4},
        '{OP_IRQ, 3'd0, 16'h0000, 16'h0001, 4'd4},  // R4 re-armed
        '{OP_WR,  3'd1, 16'h0000, 16'h0000, 4'd5},
        '{OP_IRQ, 3'd0, 16'h0000, 16'h0000, 4'd5},  // R5 masked
        '{OP_RD,  3'd2, 16'h0000, 16'h0001, 4'd5},  // R5
        '{OP_WR,  3'd1, 16'h0002, 16'h0000, 4'd4},
        '{OP_IRQ, 3'd0, 16'h0000, 16'h0001, 4'd4},  // R4
        '{OP_WR,  3'd3, 16'h0080, 16'h0000, 4'd7},
        '{OP_WR,  3'd0, 16'h0034, 16'h0000, 4'd7},
        '{OP_WR,  3'd1, 16'h0012, 16'h0000, 4'd7},
        '{OP_RD,  3'd0, 16'h0000, 16'h0034, 4'd7},  // R7 divisor low
        '{OP_RD,  3'd1, 16'h0000, 16'h0012, 4'd7},  // R7 divisor high
        '{OP_RD,  3'd5, 16'h0000, 16'h0060, 4'd7},  // R7 nothing queued
        '{OP_IRQ, 3'd0, 16'h0000, 16'h0001, 4'd7},  // R7 enable kept
        '{OP_WR,  3'd0, 16'h0000, 16'h0000, 4'd7},
        '{OP_WR,  3'd1, 16'h0000, 16'h0000, 4'd7},
        '{OP_WR,  3'd3, 16'h0003, 16'h0000, 4'd7},
        '{OP_RD,  3'd1, 16'h0000, 16'h0002, 4'd7},  // R7 enable untouched
        '{OP_RD,  3'd3, 16'h0000, 16'h0003, 4'd12}, // R12 format readback
        '{OP_WR,  3'd4, 16'h8ADA, 16'h0000, 4'd10},
        '{OP_RD,  3'd4, 16'h0000, 16'h8ADA, 4'd10}, // R10 fractional readback
        '{OP_WR,  3'd4, 16'h0000, 16'h0000, 4'd10},
        '{OP_RD,  3'd2, 16'h0000, 16'h0002, 4'd3}   // R3 ack before frames
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        txd, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sertx_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .txd       (txd),
        .irq       (irq)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] got, input logic [15:0] expv);
        n_chk++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%04h expected 0x%04h", req, what, got, expv);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rx_frame(input string req, input logic [7:0] expb,
                            input int nbits, input int nstop, input int per);
        int guard = 0;
        while (txd !== 1'b0 && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        repeat (per / 2) @(negedge clk);
        check(req, "start bit", {15'b0, txd}, 16'h0000);
        for (int i = 0; i < nbits; i++) begin
            repeat (per) @(negedge clk);
            check(req, $sformatf("data bit %0d", i), {15'b0, txd}, {15'b0, expb[i]});
        end
        for (int s = 0; s < nstop; s++) begin
            repeat (per) @(negedge clk);
            check(req, "stop bit", {15'b0, txd}, 16'h0001);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "txd after reset", {15'b0, txd}, 16'h0001);
        check("R1", "irq after reset", {15'b0, irq}, 16'h0000);
        bus_read(3'd4, rd);
        check("R1", "fractional reg after reset", rd, 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i].req);
            case (VEC[i].op)
                OP_WR: bus_write(VEC[i].addr, VEC[i].data);
                OP_RD: begin
                    bus_read(VEC[i].addr, rd);
                    check(tag, $sformatf("vector %0d read", i), rd, VEC[i].expv);
                end
                default: check(tag, $sformatf("vector %0d irq", i), {15'b0, irq}, VEC[i].expv);
            endcase
        end

        // R6: data write withdraws irq, hand-off one cycle later restores it
        bus_write(3'd0, 16'h00A5);
        check("R6", "irq right after data write", {15'b0, irq}, 16'h0000);
        @(negedge clk);
        check("R6", "irq after hand-off", {15'b0, irq}, 16'h0001);
        bus_read(3'd5, rd);
        check("R11", "status while shifting", rd, 16'h0020);
        // R9: divisor 0 acts as 1, 32 clocks per bit; R8: 8N1
        rx_frame("R9", 8'hA5, 8, 1, 32);
        repeat (40) @(negedge clk);
        bus_read(3'd5, rd);
        check("R11", "status after frame", rd, 16'h0060);

        // R8/R9: divisor 2, two stop bits, back-to-back bytes
        bus_write(3'd3, 16'h0080);
        bus_write(3'd0, 16'h0002);
        bus_write(3'd3, 16'h0007);
        bus_write(3'd0, 16'h003C);
        repeat (2) @(negedge clk);
        bus_write(3'd0, 16'h00C3);
        bus_read(3'd5, rd);
        check("R11", "status with byte queued", rd, 16'h0000);
        check("R6", "irq while holding full", {15'b0, irq}, 16'h0000);
        rx_frame("R8", 8'h3C, 8, 2, 64);
        rx_frame("R8", 8'hC3, 8, 2, 64);
        repeat (80) @(negedge clk);

        // R10: divisor 1, M=1 N=1024 gives 48 clocks per bit
        bus_write(3'd3, 16'h0080);
        bus_write(3'd0, 16'h0001);
        bus_write(3'd3, 16'h0003);
        bus_write(3'd4, 16'h8C00);
        bus_write(3'd0, 16'h005A);
        rx_frame("R10", 8'h5A, 8, 1, 48);
        repeat (60) @(negedge clk);

        // R8: 5-bit word, fractional off
        bus_write(3'd4, 16'h0000);
        bus_write(3'd3, 16'h0000);
        bus_write(3'd0, 16'h0013);
        rx_frame("R8", 8'h13, 5, 1, 32);
        repeat (40) @(negedge clk);
        check("R8", "line idle after frames", {15'b0, txd}, 16'h0001);
        bus_read(3'd2, rd);
        check("R2", "identification after frames", rd, 16'h0002);
        bus_read(3'd2, rd);
        check("R3", "identification after ack", rd, 16'h0001);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule